// File: doc/BRIEF.md
# Bunch-Train Hit Timestamp Buffer

This block keeps the hit history of a small group of binary pixels in a detector that runs without a hardware trigger. Activity comes in trains of collisions. A train-start pulse opens an acquisition window. A collision strobe then marks each collision, and the block numbers the collisions from zero with a saturating 14-bit counter. On every strobe, each pixel whose discriminated hit bit is high produces one entry. The entry holds that pixel's index and the current collision number, and it goes into an on-chip store.

A train-end pulse closes the window. The block first drains any hits that are still pending. It then streams the stored entries out over a valid/ready interface and adds one status word that reports whether any hits were lost because the store reached its programmed limit. When the status word is accepted, the block pulses done, empties the store and waits for the next train. If a train-start arrives while a readout is still in progress, the readout is dropped, a sticky error flag is set and the new train is acquired.

Top module: `hit_stamp_buffer`

## Requirements
- R1: After reset the block is idle: out_valid, out_last, done and abort_err are all low.
- R2: A train_start pulse in idle opens acquisition. The first strobe is stamped with collision number 0, and each later strobe is stamped one higher. Strobes, hits and train_end pulses seen while idle are ignored.
- R3: The collision number saturates at 16383. All strobes after that one are stamped 16383.
- R4: Pixels that fire on the same strobe are stored in ascending pixel-index order, at most one entry per clock. Strobes that carry hits must be at least NPIX+1 cycles apart.
- R5: After train_end, entries are streamed out in the order they were stored. Each entry word has the pixel index in bits 16:14 and the collision number in bits 13:0.
- R6: The entry limit is min(max_entries, DEPTH), sampled at train_start. Hits that arrive once the limit is reached are dropped and set a sticky overflow flag. Entries already stored are not changed.
- R7: Every readout ends with exactly one status word, marked by out_last high. Bit 0 of the status word is the overflow flag and all its other bits are zero.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R9: done pulses for one cycle, in the cycle after the status word is accepted. The block then returns to idle with an empty store and a cleared overflow flag.
- R10: A train_start during readout sets abort_err, which stays set until reset. It abandons the readout and starts a new acquisition with an empty store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | One-cycle pulse that opens an acquisition window |
| train_end | input | 1 | One-cycle pulse that closes the acquisition window |
| coll_strobe | input | 1 | One-cycle pulse per collision |
| pix_hit | input | NPIX | Discriminated hit bits, sampled on the strobe |
| max_entries | input | CNT_W | Requested entry limit |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Readout word available |
| out_data | output | IDX_W+14 | Entry word or status word |
| out_last | output | 1 | Marks the status word |
| done | output | 1 | One-cycle pulse after the status word is accepted |
| abort_err | output | 1 | Sticky: a train started before the readout finished |

## Verification
The bench drives trains of random hit patterns and puts them side by side with the directed corner cases. Several pixels firing on one strobe catch a priority picker that stores in the wrong order. A limit of zero, and a limit below the hit count, catch a store that overwrites or miscounts and a status word that misreports overflow. A run of more than 16383 strobes shows a counter that wraps to small numbers instead of saturating. An abort partway through readout exposes entries that leak into the next train. Strobes sent while idle show a counter or store that is active outside the window. Random back-pressure on out_ready catches words that change or get skipped while stalled.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int TS_W = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CLOSE, ST_READ} hsb_state_e;

  // saturating collision-number step
  function automatic logic [TS_W-1:0] ts_next(input logic [TS_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  // lowest set bit position; 0 when none set
  function automatic int unsigned first_set(input logic [63:0] bits);
    for (int i = 0; i < 64; i++) begin
      if (bits[i]) return i;
    end
    return 0;
  endfunction

  // effective entry limit
  function automatic int unsigned clip_cap(input int unsigned req, input int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction
endpackage

// File: rtl/coll_counter.sv
module coll_counter
  import hsb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  output logic [TS_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (restart) value <= '0;
    else if (step)    value <= ts_next(value);
  end
endmodule

// File: rtl/hit_queue.sv
module hit_queue
  import hsb_pkg::*;
#(
  parameter int NPIX  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [NPIX-1:0]  load_bits,
  input  logic [TS_W-1:0]  load_ts,
  output logic             item_valid,
  output logic [IDX_W-1:0] item_idx,
  output logic [TS_W-1:0]  item_ts
);
  logic [NPIX-1:0] pend;
  logic [TS_W-1:0] ts_q;

  assign item_valid = |pend;
  assign item_idx   = IDX_W'(first_set(64'(pend)));
  assign item_ts    = ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ts_q <= '0;
    end else if (flush) begin
      pend <= '0;
    end else if (load) begin
      pend <= load_bits;
      ts_q <= load_ts;
    end else if (item_valid) begin
      pend <= pend & ~(NPIX'(1) << item_idx);
    end
  end
endmodule

// File: rtl/entry_store.sv
module entry_store
  import hsb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 3,
  parameter int CNT_W = 7,
  parameter int AW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  wr_req,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [TS_W-1:0]       wr_ts,
  input  logic [CNT_W-1:0]      cap,
  input  logic [AW-1:0]         rd_addr,
  output logic [CNT_W-1:0]      count,
  output logic                  ovf,
  output logic [IDX_W+TS_W-1:0] rd_word,
  output logic                  wr_fire,
  output logic                  drop_fire
);
  logic [IDX_W+TS_W-1:0] mem [DEPTH];
  logic room;

  assign room      = count < cap;
  assign wr_fire   = wr_req && !clear && room;
  assign drop_fire = wr_req && !clear && !room;
  assign rd_word   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[count[AW-1:0]] <= {wr_idx, wr_ts};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_fire)   count <= count + 1'b1;
      if (drop_fire) ovf   <= 1'b1;
    end
  end
endmodule

// File: rtl/hit_stamp_buffer.sv
module hit_stamp_buffer
  import hsb_pkg::*;
#(
  parameter int NPIX   = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = IDX_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_start,
  input  logic              train_end,
  input  logic              coll_strobe,
  input  logic [NPIX-1:0]   pix_hit,
  input  logic [CNT_W-1:0]  max_entries,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic              abort_err
);
  hsb_state_e state;
  logic [CNT_W-1:0] rd_ptr, cap_q, ent_cnt;
  logic [TS_W-1:0]  coll_val, item_ts;
  logic [IDX_W-1:0] item_idx;
  logic [WORD_W-1:0] rd_word;
  logic item_valid, ovf;

  // named events for the checker
  logic start_new, abort_ev, strobe_ev, rd_fire, at_status, final_ev;
  logic wr_fire, drop_fire, store_clear;

  assign start_new   = train_start && (state == ST_IDLE || state == ST_READ);
  assign abort_ev    = train_start && (state == ST_READ);
  assign strobe_ev   = coll_strobe && (state == ST_ACQ);
  assign rd_fire     = out_valid && out_ready;
  assign at_status   = (rd_ptr == ent_cnt);
  assign final_ev    = rd_fire && at_status && !train_start;
  assign store_clear = start_new || final_ev;

  coll_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(start_new), .step(strobe_ev), .value(coll_val)
  );

  hit_queue #(.NPIX(NPIX), .IDX_W(IDX_W)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(start_new), .load(strobe_ev),
    .load_bits(pix_hit), .load_ts(coll_val),
    .item_valid(item_valid), .item_idx(item_idx), .item_ts(item_ts)
  );

  entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .AW(AW)) u_st (
    .clk(clk), .rst_n(rst_n), .clear(store_clear), .wr_req(item_valid),
    .wr_idx(item_idx), .wr_ts(item_ts), .cap(cap_q), .rd_addr(rd_ptr[AW-1:0]),
    .count(ent_cnt), .ovf(ovf), .rd_word(rd_word),
    .wr_fire(wr_fire), .drop_fire(drop_fire)
  );

  assign out_valid = (state == ST_READ);
  assign out_last  = out_valid && at_status;
  assign out_data  = at_status ? {{(WORD_W-1){1'b0}}, ovf} : rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rd_ptr    <= '0;
      cap_q     <= '0;
      done      <= 1'b0;
      abort_err <= 1'b0;
    end else begin
      done <= final_ev;
      if (abort_ev) abort_err <= 1'b1;
      if (start_new) begin
        state  <= ST_ACQ;
        rd_ptr <= '0;
        cap_q  <= CNT_W'(clip_cap(int'(max_entries), DEPTH));
      end else begin
        unique case (state)
          ST_ACQ:   if (train_end) state <= ST_CLOSE;
          ST_CLOSE: if (!item_valid) begin
            state  <= ST_READ;
            rd_ptr <= '0;
          end
          ST_READ: if (rd_fire) begin
            if (at_status) state <= ST_IDLE;
            else           rd_ptr <= rd_ptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker
  import hsb_pkg::*;
#(
  parameter int NPIX   = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int WORD_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              train_start,
  input hsb_state_e        state,
  input logic [TS_W-1:0]   coll_val,
  input logic [CNT_W-1:0]  ent_cnt,
  input logic [CNT_W-1:0]  cap_q,
  input logic              wr_fire,
  input logic              drop_fire,
  input logic              rd_fire,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [WORD_W-1:0] out_data,
  input logic              done,
  input logic              abort_err
);
  // R6
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cnt <= cap_q);
  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |-> (ent_cnt == cap_q));
  // R4
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_fire, drop_fire}));
  // R6
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !train_start && !(rd_fire && out_last)) |=> ent_cnt == $past(ent_cnt) + 1'b1);
  // R3
  ts_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&coll_val) && !train_start) |=> (&coll_val));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !train_start) |=> out_valid && $stable(out_data) && $stable(out_last));
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_fire && out_last));
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (train_start && state == ST_READ) |=> abort_err && state == ST_ACQ && ent_cnt == '0);
  // R10
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |=> abort_err);
endmodule

bind hit_stamp_buffer hsb_checker #(
  .NPIX(NPIX), .DEPTH(DEPTH), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .train_start(train_start), .state(state),
  .coll_val(coll_val), .ent_cnt(ent_cnt), .cap_q(cap_q),
  .wr_fire(wr_fire), .drop_fire(drop_fire), .rd_fire(rd_fire),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_data(out_data), .done(done), .abort_err(abort_err)
);

// File: tb/sim_hit_stamp_buffer.sv
module sim_hit_stamp_buffer;
  localparam int NPIX = 8;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;
  localparam int WORD_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_start = 0, train_end = 0, coll_strobe = 0, out_ready = 0;
  logic [NPIX-1:0] pix_hit = '0;
  logic [CNT_W-1:0] max_entries = '0;
  logic out_valid, out_last, done, abort_err;
  logic [WORD_W-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int ncoll, nent, cap;
  bit ovf_m;
  logic [WORD_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  hit_stamp_buffer #(.NPIX(NPIX), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .coll_strobe(coll_strobe), .pix_hit(pix_hit), .max_entries(max_entries),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .done(done), .abort_err(abort_err)
  );

  function automatic int bench_cap(int m);
    return (m < DEPTH) ? m : DEPTH;
  endfunction

  function automatic logic [WORD_W-1:0] entry_word(int idx, int ts);
    logic [2:0] i = idx[2:0];
    logic [13:0] t = ts[13:0];
    return {i, t};
  endfunction

  function automatic logic [WORD_W-1:0] status_word(bit ov);
    return {16'd0, ov};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); train_start = 1;
    @(negedge clk); train_start = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk); train_end = 1;
    @(negedge clk); train_end = 0;
  endtask

  task automatic model_reset(int m);
    cap = bench_cap(m); ncoll = 0; nent = 0; ovf_m = 0; exp_q.delete();
  endtask

  task automatic begin_train(int m);
    max_entries = CNT_W'(m);
    model_reset(m);
    pulse_start();
  endtask

  // strobe with model update
  task automatic strobe(logic [NPIX-1:0] hits, bit model);
    int ts;
    @(negedge clk); coll_strobe = 1; pix_hit = hits;
    @(negedge clk); coll_strobe = 0; pix_hit = '0;
    if (model) begin
      ts = (ncoll > 16383) ? 16383 : ncoll;
      ncoll++;
      for (int i = 0; i < NPIX; i++) begin
        if (hits[i]) begin
          if (nent < cap) begin exp_q.push_back(entry_word(i, ts)); nent++; end
          else ovf_m = 1;
        end
      end
    end
    if (hits != '0) cyc(NPIX + 1);
  endtask

  task automatic read_all(bit rand_ready, string req);
    int got = 0;
    int guard = 0;
    bit fin = 0;
    logic [WORD_W-1:0] e;
    while (!fin && guard < 5000) begin
      @(negedge clk);
      guard++;
      out_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
      if (out_valid && out_ready) begin
        e = (got < exp_q.size()) ? exp_q[got] : status_word(ovf_m);
        chk(out_data == e, req, 32'(out_data), 32'(e));
        chk(out_last == (got == exp_q.size()), "R7 last flag", 32'(out_last), 32'(got == exp_q.size()));
        if (out_last) fin = 1;
        got++;
      end
    end
    chk(got == exp_q.size() + 1, "R5 word count", got, exp_q.size() + 1);
    @(negedge clk); out_ready = 0;
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(out_valid == 1'b0, "R9 back to idle", out_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1
    chk(!out_valid && !out_last && !done && !abort_err, "R1 reset outputs",
        {out_valid, out_last, done, abort_err}, 0);
    rst_n = 1;
    cyc(2);
    chk(!out_valid && !done, "R1 idle after reset", {out_valid, done}, 0);

    // R2: activity while idle is ignored
    strobe(8'hFF, 0);
    strobe(8'h00, 0);
    pulse_end();
    cyc(2);
    chk(out_valid == 0, "R2 train_end ignored in idle", out_valid, 0);
    begin_train(10);
    strobe(8'h20, 1);
    strobe(8'h00, 1);
    strobe(8'h02, 1);
    pulse_end();
    read_all(0, "R2 numbering from zero");

    // R4: several pixels on one strobe, ascending order
    begin_train(64);
    strobe(8'hA5, 1);
    strobe(8'hFF, 1);
    pulse_end();
    read_all(1, "R4 ascending order");

    // R6: cap below hit count, overflow reported
    begin_train(5);
    strobe(8'h0F, 1);
    strobe(8'hF0, 1);
    pulse_end();
    read_all(1, "R6 cap and overflow");

    // R6: cap of zero
    begin_train(0);
    strobe(8'h01, 1);
    pulse_end();
    read_all(0, "R6 zero cap");

    // R6: request above depth clips to depth
    begin_train(100);
    for (int s = 0; s < 10; s++) strobe(8'hFF, 1);
    pulse_end();
    read_all(1, "R6 depth clip");

    // R5 R8: random trains with back-pressure
    for (int t = 0; t < 4; t++) begin
      begin_train(int'($urandom_range(0, 70)));
      for (int s = 0; s < 30; s++) begin
        logic [NPIX-1:0] h = NPIX'($urandom);
        if ($urandom % 3 == 0) h = '0;
        strobe(h, 1);
      end
      pulse_end();
      read_all(1, "R5 R8 random train");
    end

    // R3: saturation of collision number
    begin_train(4);
    strobe(8'h01, 1);
    for (int s = 0; s < 16385; s++) strobe(8'h00, 1);
    strobe(8'h04, 1);
    strobe(8'h80, 1);
    pulse_end();
    read_all(0, "R3 saturation");

    // R10: abort during readout
    begin_train(64);
    strobe(8'h3C, 1);
    pulse_end();
    begin
      int g = 0;
      while (!out_valid && g < 100) begin @(negedge clk); g++; end
    end
    chk(out_valid == 1'b1, "R10 readout pending", out_valid, 1);
    chk(abort_err == 1'b0, "R10 no error yet", abort_err, 0);
    model_reset(64);
    pulse_start();
    chk(abort_err == 1'b1, "R10 abort flag", abort_err, 1);
    chk(out_valid == 1'b0, "R10 readout abandoned", out_valid, 0);
    strobe(8'h40, 1);
    pulse_end();
    read_all(1, "R10 fresh store after abort");
    chk(abort_err == 1'b1, "R10 flag sticky", abort_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule